// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a two-level logic array that realises switching functions in disjunctive normal form. It has `N_IN` inputs, `N_TERM` product terms and `N_OUT` outputs. Each input drives the first plane twice: once as its true value and once as its complement. Each product term is a programmable AND over any chosen set of these literals. The number of terms is a free parameter and is not derived from the input count.

A build-time parameter selects how the second plane is formed. In the programmable variant, every output is a programmable OR over any of the terms. In the fixed variant, each output ORs its own contiguous, disjoint group of terms, and only the AND plane carries configuration.

The configuration is loaded serially through a shift chain clocked by `clk_i`. The outputs are purely combinational from the inputs and the stored configuration.

Top module: `sop_array`

## Requirements
- R1: Input i appears in the AND plane as two literals. The true value sits at literal index 2i and the complement at literal index 2i+1. The enable bit for term t and literal j is configuration bit t*2*N_IN + j.
- R2: A product term is 1 exactly when every literal connected to it is 1. A term with no connected literal is 0.
- R3: A term that connects both literals of the same input is 0 for every input vector.
- R4: In the programmable variant (`MODE = OR_PROG`), output k is the OR of all terms t whose configuration bit N_TERM*2*N_IN + k*N_TERM + t is set.
- R5: In the fixed variant (`MODE = OR_FIXED`), output k is the OR of terms k*G through (k+1)*G-1, with G = N_TERM/N_OUT. The chain holds only the AND-plane bits.
- R6: On each rising edge of `clk_i` with `cfg_en_i` high, `cfg_bit_i` enters the top of the chain and every stored bit moves down one place. After a full load, the first bit shifted in holds index 0. The AND plane is therefore loaded first and the OR plane after it.
- R7: While `cfg_en_i` is low, clock edges and `cfg_bit_i` leave the configuration, and so the output function, unchanged.
- R8: A low `rst_ni` clears every configuration bit at once, which drives all outputs to 0.
- R9: The outputs follow input changes combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration shift clock |
| rst_ni | input | 1 | Active-low asynchronous clear of the configuration |
| cfg_en_i | input | 1 | Shift enable for the configuration chain |
| cfg_bit_i | input | 1 | Serial configuration data |
| in_i | input | N_IN | Logic inputs |
| out_o | output | N_OUT | Sum-of-products outputs |

## Verification
The bench sweeps every input vector against a bench model for several cases:
- a term with no literal, which would read 1 if empty terms were treated as a plain AND;
- a term that holds both polarities of one input, which would show up as a swapped or shared literal index;
- single-literal terms in each polarity, which catch a reversed true/complement order.

Random configurations in both OR-plane variants expose two kinds of fault: a chain that shifts in the wrong direction or places the planes in the wrong order, and fixed groups that overlap or are off by one. Clocking with the enable low while the data line toggles catches a chain that keeps shifting. Pulsing reset after a load catches a chain that is not cleared.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic {OR_PROG = 1'b0, OR_FIXED = 1'b1} or_mode_e;

  function automatic int unsigned and_bits(int unsigned m, int unsigned l);
    return l * 2 * m;
  endfunction

  function automatic int unsigned or_bits(or_mode_e md, int unsigned l, int unsigned n);
    return (md == OR_PROG) ? l * n : 0;
  endfunction
endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] bits_o
);
  logic [W-1:0] sr_q;

  generate
    if (W == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_q <= '0;
        else if (shift_i) sr_q <= bit_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_q <= '0;
        else if (shift_i) sr_q <= {bit_i, sr_q[W-1:1]};
      end
    end
  endgenerate

  assign bits_o = sr_q;

  assert_shift_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> sr_q[W-1] == $past(bit_i));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(sr_q));
endmodule

// File: rtl/and_plane.sv
module and_plane #(
  parameter int unsigned M = 4,
  parameter int unsigned L = 8,
  localparam int unsigned LW = 2 * M
) (
  input  logic [M-1:0]    in_i,
  input  logic [L*LW-1:0] mask_i,
  output logic [L-1:0]    term_o
);
  logic [LW-1:0] lit;

  for (genvar i = 0; i < M; i++) begin : g_lit
    assign lit[2*i]   = in_i[i];
    assign lit[2*i+1] = ~in_i[i];
  end

  for (genvar t = 0; t < L; t++) begin : g_term
    logic [LW-1:0] msk;
    assign msk       = mask_i[t*LW +: LW];
    // unconnected literals read as 1; empty term forced low
    assign term_o[t] = (&(lit | ~msk)) & (|msk);

    always_comb begin
      assert_empty_term_R2: assert (msk != '0 || !term_o[t]);
    end

    for (genvar i = 0; i < M; i++) begin : g_chk
      always_comb begin
        assert_term_literal_R2: assert (!(term_o[t] && msk[2*i]) || in_i[i]);
        assert_term_cmpl_R1: assert (!(term_o[t] && msk[2*i+1]) || !in_i[i]);
      end
    end
  end
endmodule

// File: rtl/or_prog.sv
module or_prog #(
  parameter int unsigned L = 8,
  parameter int unsigned N = 4
) (
  input  logic [L-1:0]   term_i,
  input  logic [L*N-1:0] sel_i,
  output logic [N-1:0]   out_o
);
  for (genvar k = 0; k < N; k++) begin : g_out
    logic [L-1:0] sel;
    assign sel      = sel_i[k*L +: L];
    assign out_o[k] = |(term_i & sel);

    always_comb begin
      assert_unsel_zero_R4: assert (sel != '0 || !out_o[k]);
      assert_needs_term_R4: assert (!out_o[k] || (term_i != '0));
    end
  end
endmodule

// File: rtl/or_fixed.sv
module or_fixed #(
  parameter int unsigned L = 8,
  parameter int unsigned N = 4,
  localparam int unsigned G = L / N
) (
  input  logic [L-1:0] term_i,
  output logic [N-1:0] out_o
);
  for (genvar k = 0; k < N; k++) begin : g_out
    assign out_o[k] = |term_i[k*G +: G];
  end

  // disjoint groups: each high output needs its own high term
  always_comb begin
    assert_group_disjoint_R5: assert ($countones(out_o) <= $countones(term_i));
  end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int unsigned       N_IN   = 4,
  parameter int unsigned       N_TERM = 8,
  parameter int unsigned       N_OUT  = 4,
  parameter sop_pkg::or_mode_e MODE   = sop_pkg::OR_PROG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_bit_i,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_OUT-1:0]  out_o
);
  localparam int unsigned AND_W   = sop_pkg::and_bits(N_IN, N_TERM);
  localparam int unsigned OR_W    = sop_pkg::or_bits(MODE, N_TERM, N_OUT);
  localparam int unsigned CHAIN_W = AND_W + OR_W;

  logic [CHAIN_W-1:0] cfg;
  logic [N_TERM-1:0]  term;

  cfg_chain #(.W(CHAIN_W)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (cfg_en_i),
    .bit_i   (cfg_bit_i),
    .bits_o  (cfg)
  );

  and_plane #(.M(N_IN), .L(N_TERM)) u_and (
    .in_i   (in_i),
    .mask_i (cfg[AND_W-1:0]),
    .term_o (term)
  );

  generate
    if (MODE == sop_pkg::OR_PROG) begin : g_prog
      or_prog #(.L(N_TERM), .N(N_OUT)) u_or (
        .term_i (term),
        .sel_i  (cfg[CHAIN_W-1:AND_W]),
        .out_o  (out_o)
      );
    end else begin : g_fixed
      or_fixed #(.L(N_TERM), .N(N_OUT)) u_or (
        .term_i (term),
        .out_o  (out_o)
      );
    end
  endgenerate

  assert_hold_out_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> ($stable(in_i) -> $stable(out_o)));
endmodule

// File: tb/tb_sop_array.sv
module tb_sop_array;
  localparam int M     = 4;
  localparam int L     = 8;
  localparam int N     = 4;
  localparam int AW    = L * 2 * M;
  localparam int OW    = L * N;
  localparam int G     = L / N;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_a = 1'b0, en_b = 1'b0, cbit = 1'b0;
  logic [M-1:0] x = '0;
  logic [N-1:0] out_a, out_b;

  int n_chk = 0, n_bad = 0;

  logic [AW-1:0] am;
  logic [OW-1:0] om;

  always #(CLK_P/2) clk = ~clk;

  sop_array #(.N_IN(M), .N_TERM(L), .N_OUT(N), .MODE(sop_pkg::OR_PROG)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(en_a), .cfg_bit_i(cbit),
    .in_i(x), .out_o(out_a));

  sop_array #(.N_IN(M), .N_TERM(L), .N_OUT(N), .MODE(sop_pkg::OR_FIXED)) dut_pal (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(en_b), .cfg_bit_i(cbit),
    .in_i(x), .out_o(out_b));

  function automatic logic [N-1:0] model(logic [AW-1:0] a, logic [OW-1:0] o,
                                         bit pal, logic [M-1:0] v);
    logic [L-1:0] tr;
    logic [N-1:0] r;
    bit any, ok, litv;
    for (int t = 0; t < L; t++) begin
      any = 0; ok = 1;
      for (int j = 0; j < 2*M; j++) begin
        if (a[t*2*M + j]) begin
          any  = 1;
          litv = (j % 2 == 0) ? v[j/2] : !v[j/2];
          if (!litv) ok = 0;
        end
      end
      tr[t] = any && ok;
    end
    r = '0;
    for (int k = 0; k < N; k++)
      for (int t = 0; t < L; t++)
        if (pal ? (t / G == k) : o[k*L + t]) r[k] = r[k] | tr[t];
    return r;
  endfunction

  task automatic load(bit pal);
    int tot;
    tot = pal ? AW : AW + OW;
    @(negedge clk);
    if (pal) en_b = 1'b1; else en_a = 1'b1;
    for (int i = 0; i < tot; i++) begin
      cbit = (i < AW) ? am[i] : om[i - AW];
      @(negedge clk);
    end
    en_a = 1'b0; en_b = 1'b0;
  endtask

  task automatic sweep(bit pal, bit zero, string tag);
    logic [N-1:0] exp_v, act;
    for (int v = 0; v < (1 << M); v++) begin
      x = v[M-1:0];
      #1;
      exp_v = zero ? '0 : model(am, om, pal, x);
      act   = pal ? out_b : out_a;
      n_chk++;
      if (act !== exp_v) begin
        n_bad++;
        $display("FAIL %s in=%0h actual=%b expected=%b", tag, x, act, exp_v);
      end
    end
  endtask

  task automatic rand_cfg();
    for (int i = 0; i < AW; i++) am[i] = ($urandom % 5 == 0);
    for (int i = 0; i < OW; i++) om[i] = ($urandom % 3 == 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    am = '0; om = '0;
    #(CLK_P*2 + 1);
    // R8: state right after reset
    sweep(0, 1, "R8 reset PLA");
    sweep(1, 1, "R8 reset PAL");
    rst_ni = 1'b1;

    // R1: term0 = in2 true, term1 = in2 complement; out0<-t0, out1<-t1
    am = '0; om = '0;
    am[0*2*M + 2*2]   = 1'b1;
    am[1*2*M + 2*2+1] = 1'b1;
    om[0*L + 0] = 1'b1;
    om[1*L + 1] = 1'b1;
    load(0);
    sweep(0, 0, "R1 polarity");
    n_chk++;
    x = 4'b0100; #1;
    if (out_a[1:0] !== 2'b01) begin
      n_bad++; $display("FAIL R1 actual=%b expected=01", out_a[1:0]);
    end

    // R2: empty term selected alone gives 0; R3: contradictory term
    am = '0; om = '0;
    om[0*L + 3] = 1'b1;
    am[5*2*M + 0] = 1'b1; am[5*2*M + 1] = 1'b1; am[5*2*M + 6] = 1'b1;
    om[2*L + 5] = 1'b1;
    load(0);
    sweep(0, 0, "R2 empty term");
    sweep(0, 1, "R3 contradictory term");

    // R4 / R6: random programmable OR plane
    for (int r = 0; r < 8; r++) begin
      rand_cfg();
      load(0);
      sweep(0, 0, "R4 R6 random PLA");
    end

    // R7: clocks with enable low and toggling data must not disturb config
    for (int c = 0; c < 24; c++) begin
      cbit = $urandom % 2;
      @(negedge clk);
    end
    sweep(0, 0, "R7 hold PLA");

    // R9: input changes between edges (sweep runs with no clock dependence)
    @(posedge clk); #2;
    x = 4'b1010; #1;
    n_chk++;
    if (out_a !== model(am, om, 0, 4'b1010)) begin
      n_bad++; $display("FAIL R9 actual=%b expected=%b", out_a, model(am, om, 0, 4'b1010));
    end

    // R5: directed fixed group, term in output 3 group only
    am = '0;
    am[(3*G)*2*M + 2*1] = 1'b1;
    load(1);
    sweep(1, 0, "R5 fixed group");
    for (int r = 0; r < 8; r++) begin
      rand_cfg();
      load(1);
      sweep(1, 0, "R5 R6 random PAL");
    end
    for (int c = 0; c < 16; c++) begin
      cbit = ~cbit;
      @(negedge clk);
    end
    sweep(1, 0, "R7 hold PAL");

    // R8: reset after a loaded configuration
    rst_ni = 1'b0; #1;
    sweep(0, 1, "R8 clear PLA");
    sweep(1, 1, "R8 clear PAL");
    rst_ni = 1'b1;

    finish_run();
  end
endmodule